// File: doc/BRIEF.md
# Supply-Supervised Reset Sequencer

This block turns a synchronised supply-good flag and a watchdog timeout request into a system reset output. The reset is active after the block's own reset. It stays active until the supply flag has been high, without a break, for a programmable number of timebase ticks. If the flag drops during operation, the reset comes back on the next clock edge and the hold count starts again from zero. A watchdog timeout has the same effect and waits out the same hold time before release. A parameter selects whether the output is active high or active low.

The same internal reset state also drives a gate for the serial memory interface. When reset becomes active, the gate sends a one-cycle abort to a serial transfer that is in progress. While reset is active, it blocks new transfers and new nonvolatile write starts. The block sends no abort of any kind to the nonvolatile write engine, so a write that is already running completes.

Top module: `rst_seq_supervisor`

## Requirements
- R1: After rst_ni is released, the block is in reset: sys_rst_o is at its active level, bus_en_o is 0 and xfer_abort_o is 0.
- R2: Reset is released at the clock edge that samples the HOLD_TICKS-th consecutive tick_i=1 during which supply_ok_i=1 and wdog_i=0.
- R3: supply_ok_i=0 makes reset active at the next clock edge. Any low glitch restarts the hold count from zero, including a glitch during the hold.
- R4: wdog_i=1 makes reset active at the next clock edge. Release then needs the full HOLD_TICKS hold again.
- R5: At the edge where reset becomes active, xfer_abort_o is 1 for exactly one cycle if xfer_busy_i=1, and 0 otherwise. xfer_abort_o is never 1 at any other time.
- R6: While reset is active, bus_en_o=0 and nv_start_o=0. While reset is inactive, bus_en_o=1 and nv_start_o follows nv_start_req_i.
- R7: With ACTIVE_LOW=1, sys_rst_o is 0 while reset is active. With ACTIVE_LOW=0, sys_rst_o is 1 while reset is active.
- R8: Cycles with tick_i=0 do not advance the hold count, and they do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Timebase tick enable |
| supply_ok_i | input | 1 | Synchronised flag: supply above trip level |
| wdog_i | input | 1 | Watchdog timeout request |
| xfer_busy_i | input | 1 | Serial transfer in progress |
| nv_start_req_i | input | 1 | Request to start a nonvolatile write |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_LOW |
| bus_en_o | output | 1 | Serial interface may accept transfers |
| xfer_abort_o | output | 1 | One-cycle abort of the running transfer |
| nv_start_o | output | 1 | Gated nonvolatile write start |

## Verification
A hold counter in the wrong state shows up at sys_rst_o as a release that comes early or late relative to the HOLD_TICKS-th qualifying tick. It can also show as a release that no drop or watchdog request ever restarts, and this shows within one hold window. A reset flag that is stuck or does not update appears within one cycle on bus_en_o and nv_start_o. A faulty edge detector appears in the same cycle as xfer_abort_o missing, or as an abort that repeats or appears where none is expected.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_SUPPLY = 2'd1,
    CAUSE_WDOG   = 2'd2
  } restart_cause_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rst_seq_hold_timer.sv
module rst_seq_hold_timer #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = rst_seq_pkg::cnt_width(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !clear_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !run_i)  cnt_q <= '0;
    else if (tick_i)             cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rst_seq_bus_gate.sv
module rst_seq_bus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_rst_i,
  input  logic xfer_busy_i,
  input  logic nv_start_req_i,
  output logic bus_en_o,
  output logic xfer_abort_o,
  output logic nv_start_o
);
  logic in_rst_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_d <= 1'b1;
    else         in_rst_d <= in_rst_i;
  end

  assign bus_en_o     = !in_rst_i;
  assign xfer_abort_o = in_rst_i && !in_rst_d && xfer_busy_i;
  // write engine is never told to stop: a running write completes
  assign nv_start_o   = nv_start_req_i && !in_rst_i;
endmodule

// File: rtl/rst_seq_supervisor.sv
module rst_seq_supervisor #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic wdog_i,
  input  logic xfer_busy_i,
  input  logic nv_start_req_i,
  output logic sys_rst_o,
  output logic bus_en_o,
  output logic xfer_abort_o,
  output logic nv_start_o
);
  import rst_seq_pkg::*;

  restart_cause_e cause;
  logic in_rst_q, expire;

  always_comb begin
    if (!supply_ok_i) cause = CAUSE_SUPPLY;
    else if (wdog_i)  cause = CAUSE_WDOG;
    else              cause = CAUSE_NONE;
  end

  rst_seq_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (cause != CAUSE_NONE),
    .run_i    (in_rst_q),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 in_rst_q <= 1'b1;
    else if (cause != CAUSE_NONE) in_rst_q <= 1'b1;
    else if (expire)             in_rst_q <= 1'b0;
  end

  rst_seq_bus_gate u_gate (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .in_rst_i       (in_rst_q),
    .xfer_busy_i    (xfer_busy_i),
    .nv_start_req_i (nv_start_req_i),
    .bus_en_o       (bus_en_o),
    .xfer_abort_o   (xfer_abort_o),
    .nv_start_o     (nv_start_o)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign sys_rst_o = !in_rst_q;
    end else begin : g_high
      assign sys_rst_o = in_rst_q;
    end
  endgenerate
endmodule

// File: rtl/rst_seq_supervisor_chk.sv
module rst_seq_supervisor_chk #(
  parameter int unsigned HOLD_TICKS = 200,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic supply_ok_i,
  input logic wdog_i,
  input logic xfer_busy_i,
  input logic nv_start_req_i,
  input logic sys_rst_o,
  input logic bus_en_o,
  input logic xfer_abort_o,
  input logic nv_start_o
);
  logic asserted;
  int unsigned ok_ticks;
  assign asserted = ACTIVE_LOW ? !sys_rst_o : sys_rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_ticks <= 0;
    else if (!supply_ok_i || wdog_i) ok_ticks <= 0;
    else if (tick_i && ok_ticks < HOLD_TICKS) ok_ticks <= ok_ticks + 1;
  end

  a_r3_drop_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> asserted);
  a_r4_wdog_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_i |=> asserted);
  a_r2_release_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asserted) |-> ($past(ok_ticks) == HOLD_TICKS - 1) && $past(tick_i));
  a_r6_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asserted |-> (!bus_en_o && !nv_start_o));
  a_r5_abort_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(asserted) && xfer_busy_i) |-> xfer_abort_o);
  a_r5_abort_only_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_abort_o |-> ($rose(asserted) && xfer_busy_i));
  a_r8_no_tick_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asserted && !tick_i) |=> asserted);
endmodule

bind rst_seq_supervisor rst_seq_supervisor_chk #(
  .HOLD_TICKS(HOLD_TICKS), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (.*);

// File: tb/rst_seq_supervisor_test.sv
module rst_seq_supervisor_test;
  localparam int unsigned HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, sup_ok = 1'b0, wdog = 1'b0, busy = 1'b0, nv_req = 1'b0;
  logic sys_rst, bus_en, abort_o, nv_start, sys_rst_h;
  logic unused_bus, unused_abort, unused_nv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_seq_supervisor #(.HOLD_TICKS(HOLD), .ACTIVE_LOW(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup_ok), .wdog_i(wdog),
    .xfer_busy_i(busy), .nv_start_req_i(nv_req), .sys_rst_o(sys_rst),
    .bus_en_o(bus_en), .xfer_abort_o(abort_o), .nv_start_o(nv_start));

  rst_seq_supervisor #(.HOLD_TICKS(HOLD), .ACTIVE_LOW(1'b0)) uut_hi (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup_ok), .wdog_i(wdog),
    .xfer_busy_i(busy), .nv_start_req_i(nv_req), .sys_rst_o(sys_rst_h),
    .bus_en_o(unused_bus), .xfer_abort_o(unused_abort), .nv_start_o(unused_nv));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bring reset to released state from a clean start of a hold
  task automatic release_now();
    sup_ok = 1'b1; tick = 1'b1; wdog = 1'b0;
    cyc(HOLD);
  endtask

  task automatic t_reset_state();
    chk("R1 sys_rst", sys_rst, 1'b0);
    chk("R1 bus_en", bus_en, 1'b0);
    chk("R1 abort", abort_o, 1'b0);
    chk("R7 high polarity in reset", sys_rst_h, 1'b1);
  endtask

  task automatic t_powerup_release();
    sup_ok = 1'b1; tick = 1'b1;
    cyc(HOLD - 1);
    chk("R2 held one tick before", sys_rst, 1'b0);
    cyc(1);
    chk("R2 released after hold", sys_rst, 1'b1);
    chk("R7 high polarity released", sys_rst_h, 1'b0);
    chk("R6 bus open", bus_en, 1'b1);
  endtask

  task automatic t_glitch_restart();
    sup_ok = 1'b0; cyc(1);
    chk("R3 drop asserts", sys_rst, 1'b0);
    sup_ok = 1'b1; cyc(HOLD - 5);
    sup_ok = 1'b0; cyc(1);
    sup_ok = 1'b1;
    cyc(HOLD - 1);
    chk("R3 glitch restarts count", sys_rst, 1'b0);
    cyc(1);
    chk("R3 release after full hold", sys_rst, 1'b1);
  endtask

  task automatic t_tick_stall();
    sup_ok = 1'b0; cyc(1);
    sup_ok = 1'b1; tick = 1'b1; cyc(HOLD - 1);
    tick = 1'b0; cyc(10);
    chk("R8 no tick keeps reset", sys_rst, 1'b0);
    tick = 1'b1; cyc(1);
    chk("R8 count kept across stall", sys_rst, 1'b1);
  endtask

  task automatic t_wdog_abort();
    busy = 1'b1; wdog = 1'b1; cyc(1);
    wdog = 1'b0;
    chk("R4 watchdog asserts", sys_rst, 1'b0);
    chk("R5 abort on entry", abort_o, 1'b1);
    cyc(1);
    chk("R5 abort single cycle", abort_o, 1'b0);
    cyc(HOLD - 2);
    chk("R4 watchdog hold not done", sys_rst, 1'b0);
    cyc(1);
    chk("R4 watchdog release", sys_rst, 1'b1);
    busy = 1'b0;
    sup_ok = 1'b0; cyc(1);
    chk("R5 no abort when idle", abort_o, 1'b0);
    release_now();
  endtask

  task automatic t_nv_gate();
    nv_req = 1'b1; cyc(1);
    chk("R6 nv start passes", nv_start, 1'b1);
    sup_ok = 1'b0; cyc(1);
    chk("R6 nv start blocked", nv_start, 1'b0);
    chk("R6 bus closed", bus_en, 1'b0);
    nv_req = 1'b0;
    release_now();
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset_state();
    t_powerup_release();
    t_glitch_restart();
    t_tick_stall();
    t_wdog_abort();
    t_nv_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule